// File: doc/BRIEF.md
# Interrupt-Enable Flag Control Unit

This unit carries out the two instructions that clear and set the maskable-interrupt enable bit of a processor's flag register. It applies the privilege rules for each operating mode: real, protected and virtual-8086. Depending on the mode, the current privilege level (CPL), the two-bit I/O privilege field (IOPL), two virtualisation enables and the pending-virtual-interrupt bit, the instruction does one of three things. It writes the real interrupt flag, it writes the virtual interrupt flag instead, or it raises a general-protection fault whose error code is zero.

The unit owns the interrupt flag, the virtual interrupt flag and a one-instruction interrupt shadow. A set instruction that actually turns interrupts on opens the shadow and pulses an asynchronous-event strobe, so that the pipeline re-examines pending interrupts. The shadow closes when the retire strobe reports that the next instruction has completed. Every result appears one clock after the operation is presented.

Top module: `intr_enable_ctl`

## Requirements
- R1: While reset is held and after it is released, the interrupt flag, the virtual flag, the shadow, the fault strobe and the event strobe are all 0.
- R2: In real mode (mode code 00, and code 11, which is treated the same way) a clear operation writes the interrupt flag to 0 and a set operation writes it to 1. Neither operation ever faults.
- R3: A clear operation in protected mode (code 01) works as follows. If the protected virtual-interrupt enable is 1, CPL is 3 and IOPL is below 3, it clears the virtual flag and leaves the interrupt flag alone. Otherwise it faults when IOPL < CPL, and else it clears the interrupt flag.
- R4: A set operation in protected mode works as follows. If the protected virtual-interrupt enable is 1, CPL is 3 and IOPL is below 3, it sets the virtual flag when the pending bit is 0 and faults when the pending bit is 1. Otherwise it faults when CPL > IOPL, and else it sets the interrupt flag.
- R5: A clear operation in virtual-8086 mode (code 10) with IOPL not equal to 3 clears the virtual flag when the virtual-mode extension is enabled, and faults when it is not. With IOPL equal to 3 it clears the interrupt flag.
- R6: A set operation in virtual-8086 mode with IOPL not equal to 3 sets the virtual flag when the extension is enabled and the pending bit is 0, and faults in every other case. With IOPL equal to 3 it sets the interrupt flag.
- R7: A fault appears as a fault strobe lasting one cycle, with an error code of 0. A fault leaves the interrupt flag, the virtual flag and the shadow unchanged.
- R8: A set operation that takes the interrupt flag from 0 to 1 raises the shadow and a one-cycle event strobe. When the flag was already 1, neither the shadow nor the strobe changes.
- R9: The shadow stays at 1 until a cycle with the retire strobe high, and it reads 0 on the following cycle. When a shadow-raising operation and a retire fall in the same cycle, the shadow is raised.
- R10: Results of an operation appear one clock after the cycle in which it was presented. A cycle without an operation changes neither flag and produces no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op_set | input | 1 | 1 = set operation, 0 = clear operation |
| cpu_mode | input | 2 | 00 real, 01 protected, 10 virtual-8086, 11 treated as real |
| cur_priv | input | 2 | Current privilege level |
| io_priv | input | 2 | I/O privilege field |
| vm_ext_en | input | 1 | Virtual-mode extension enabled |
| pm_virt_en | input | 1 | Protected-mode virtual interrupts enabled |
| virt_pend | input | 1 | Virtual interrupt pending bit |
| retire | input | 1 | The instruction after the one that opened the shadow has retired |
| intr_flag | output | 1 | Interrupt-enable flag |
| virt_flag | output | 1 | Virtual interrupt flag |
| intr_shadow | output | 1 | One-instruction interrupt inhibit |
| async_evt | output | 1 | One-cycle asynchronous-event strobe |
| gp_fault | output | 1 | One-cycle general-protection fault strobe |
| gp_err_code | output | 16 | Fault error code (always 0) |

## Verification
Two functions can land in the same cycle: a set operation that opens the shadow, and the retire strobe that would close it. The bench presents both in one cycle and expects the shadow to read 1 afterwards. It then presents the retire strobe alone and expects the shadow to read 0. A clear operation together with a retire is also checked; there the shadow must close while the interrupt flag falls. Around this, a sweep covers every combination of mode, privilege, enables, pending bit and starting flag values, and compares the result against a model written from the requirements.

// File: rtl/intr_ctl_pkg.sv
`timescale 1ns/1ps
package intr_ctl_pkg;
    typedef enum logic [1:0] {
        MODE_REAL = 2'b00,
        MODE_PROT = 2'b01,
        MODE_V86  = 2'b10,
        MODE_RSVD = 2'b11
    } cpu_mode_e;

    typedef enum logic [1:0] {
        ACT_NONE   = 2'b00,
        ACT_WR_IF  = 2'b01,
        ACT_WR_VIF = 2'b10,
        ACT_FAULT  = 2'b11
    } action_e;

    typedef struct packed {
        logic intr_en;
        logic virt_en;
        logic fault;
        logic evt;
    } flag_state_t;
endpackage

// File: rtl/intr_ctl_policy.sv
`timescale 1ns/1ps
module intr_ctl_policy
    import intr_ctl_pkg::*;
#(
    parameter int PRIV_W = 2
) (
    input  logic              op_valid,
    input  logic              op_set,
    input  logic [1:0]        cpu_mode,
    input  logic [PRIV_W-1:0] cur_priv,
    input  logic [PRIV_W-1:0] io_priv,
    input  logic              vm_ext_en,
    input  logic              pm_virt_en,
    input  logic              virt_pend,
    output action_e           act
);
    localparam logic [PRIV_W-1:0] PRIV_USER = {PRIV_W{1'b1}};

    logic user_low_iopl;
    logic iopl_full;

    always_comb begin
        user_low_iopl = (cur_priv == PRIV_USER) && (io_priv != PRIV_USER);
        iopl_full     = (io_priv == PRIV_USER);
        act           = ACT_NONE;
        if (op_valid) begin
            unique case (cpu_mode_e'(cpu_mode))
                MODE_PROT: begin
                    if (pm_virt_en && user_low_iopl) begin
                        if (op_set && virt_pend) act = ACT_FAULT;
                        else                     act = ACT_WR_VIF;
                    end else if (op_set) begin
                        act = (cur_priv > io_priv) ? ACT_FAULT : ACT_WR_IF;
                    end else begin
                        act = (io_priv < cur_priv) ? ACT_FAULT : ACT_WR_IF;
                    end
                end
                MODE_V86: begin
                    if (iopl_full)                         act = ACT_WR_IF;
                    else if (vm_ext_en && !(op_set && virt_pend)) act = ACT_WR_VIF;
                    else                                   act = ACT_FAULT;
                end
                default: act = ACT_WR_IF;
            endcase
        end
    end
endmodule

// File: rtl/intr_ctl_shadow.sv
`timescale 1ns/1ps
module intr_ctl_shadow (
    input  logic clk,
    input  logic rst_n,
    input  logic raise,
    input  logic retire,
    output logic shadow
);
    logic shadow_d, shadow_q;

    always_comb begin
        shadow_d = shadow_q;
        if (retire) shadow_d = 1'b0;
        if (raise)  shadow_d = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) shadow_q <= 1'b0;
        else        shadow_q <= shadow_d;
    end

    assign shadow = shadow_q;
endmodule

// File: rtl/intr_enable_ctl.sv
`timescale 1ns/1ps
module intr_enable_ctl
    import intr_ctl_pkg::*;
#(
    parameter int PRIV_W = 2,
    parameter int ERR_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic              op_set,
    input  logic [1:0]        cpu_mode,
    input  logic [PRIV_W-1:0] cur_priv,
    input  logic [PRIV_W-1:0] io_priv,
    input  logic              vm_ext_en,
    input  logic              pm_virt_en,
    input  logic              virt_pend,
    input  logic              retire,
    output logic              intr_flag,
    output logic              virt_flag,
    output logic              intr_shadow,
    output logic              async_evt,
    output logic              gp_fault,
    output logic [ERR_W-1:0]  gp_err_code
);
    action_e     act;
    flag_state_t st_d, st_q;
    logic        raise_shadow;

    intr_ctl_policy #(.PRIV_W(PRIV_W)) u_policy (
        .op_valid   (op_valid),
        .op_set     (op_set),
        .cpu_mode   (cpu_mode),
        .cur_priv   (cur_priv),
        .io_priv    (io_priv),
        .vm_ext_en  (vm_ext_en),
        .pm_virt_en (pm_virt_en),
        .virt_pend  (virt_pend),
        .act        (act)
    );

    always_comb begin
        st_d         = st_q;
        st_d.fault   = 1'b0;
        st_d.evt     = 1'b0;
        raise_shadow = 1'b0;
        unique case (act)
            ACT_WR_IF: begin
                st_d.intr_en = op_set;
                raise_shadow = op_set && !st_q.intr_en;
                st_d.evt     = raise_shadow;
            end
            ACT_WR_VIF: st_d.virt_en = op_set;
            ACT_FAULT:  st_d.fault   = 1'b1;
            default:    ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    intr_ctl_shadow u_shadow (
        .clk    (clk),
        .rst_n  (rst_n),
        .raise  (raise_shadow),
        .retire (retire),
        .shadow (intr_shadow)
    );

    assign intr_flag   = st_q.intr_en;
    assign virt_flag   = st_q.virt_en;
    assign async_evt   = st_q.evt;
    assign gp_fault    = st_q.fault;
    assign gp_err_code = {ERR_W{1'b0}};
endmodule

// File: rtl/intr_enable_ctl_chk.sv
`timescale 1ns/1ps
module intr_enable_ctl_chk (
    input logic clk,
    input logic rst_n,
    input logic op_valid,
    input logic op_set,
    input logic retire,
    input logic intr_flag,
    input logic virt_flag,
    input logic intr_shadow,
    input logic async_evt,
    input logic gp_fault
);
    // R7
    fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid ##1 gp_fault |-> $stable(intr_flag) && $stable(virt_flag) && $stable(intr_shadow));

    // R8
    evt_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        async_evt |-> intr_shadow && intr_flag && !$past(intr_flag));

    // R8
    shadow_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(intr_shadow) |-> async_evt);

    // R7
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(gp_fault && async_evt));

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> $stable(intr_flag) && $stable(virt_flag) && !gp_fault && !async_evt);

    // R9
    retire_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        retire && !(op_valid && op_set) |=> !intr_shadow);
endmodule

bind intr_enable_ctl intr_enable_ctl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .op_valid    (op_valid),
    .op_set      (op_set),
    .retire      (retire),
    .intr_flag   (intr_flag),
    .virt_flag   (virt_flag),
    .intr_shadow (intr_shadow),
    .async_evt   (async_evt),
    .gp_fault    (gp_fault)
);

// File: tb/intr_enable_ctl_tb.sv
`timescale 1ns/1ps
module intr_enable_ctl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0, op_set = 1'b0;
    logic [1:0]  cpu_mode = 2'b00, cur_priv = 2'b00, io_priv = 2'b00;
    logic        vm_ext_en = 1'b0, pm_virt_en = 1'b0, virt_pend = 1'b0, retire = 1'b0;
    logic        intr_flag, virt_flag, intr_shadow, async_evt, gp_fault;
    logic [15:0] gp_err_code;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    intr_enable_ctl u_dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_set(op_set),
        .cpu_mode(cpu_mode), .cur_priv(cur_priv), .io_priv(io_priv),
        .vm_ext_en(vm_ext_en), .pm_virt_en(pm_virt_en), .virt_pend(virt_pend),
        .retire(retire), .intr_flag(intr_flag), .virt_flag(virt_flag),
        .intr_shadow(intr_shadow), .async_evt(async_evt), .gp_fault(gp_fault),
        .gp_err_code(gp_err_code)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // drive one cycle of stimulus, then return at the next falling edge with inputs idle
    task automatic apply(input logic v, input logic s, input logic [1:0] m, input logic [1:0] c,
                         input logic [1:0] i, input logic vm, input logic pv, input logic vp,
                         input logic rt);
        @(negedge clk);
        op_valid = v; op_set = s; cpu_mode = m; cur_priv = c; io_priv = i;
        vm_ext_en = vm; pm_virt_en = pv; virt_pend = vp; retire = rt;
        @(negedge clk);
        op_valid = 1'b0; retire = 1'b0;
    endtask

    // expected action: 0 none, 1 write IF, 2 write VIF, 3 fault
    function automatic int model(input logic s, input logic [1:0] m, input int c, input int i,
                                 input logic vm, input logic pv, input logic vp);
        if (m == 2'b01) begin
            if (pv && c == 3 && i < 3) return (s && vp) ? 3 : 2;
            if (s) return (c > i) ? 3 : 1;
            return (i < c) ? 3 : 1;
        end
        if (m == 2'b10) begin
            if (i == 3) return 1;
            if (!vm) return 3;
            if (s && vp) return 3;
            return 2;
        end
        return 1;
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 if", intr_flag, 0);
        check("R1 vif", virt_flag, 0);
        check("R1 shadow", intr_shadow, 0);
        check("R1 strobes", {gp_fault, async_evt}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", {intr_flag, virt_flag, intr_shadow, gp_fault, async_evt}, 0);

        for (int s = 0; s < 2; s++)
        for (int m = 0; m < 4; m++)
        for (int c = 0; c < 4; c++)
        for (int i = 0; i < 4; i++)
        for (int vm = 0; vm < 2; vm++)
        for (int pv = 0; pv < 2; pv++)
        for (int vp = 0; vp < 2; vp++)
        for (int if0 = 0; if0 < 2; if0++)
        for (int vf0 = 0; vf0 < 2; vf0++) begin
            int a;
            logic e_if, e_vf, e_sh, e_evt, e_flt;
            string tag;
            // preset: IF via real mode, VIF via v86 with extension, then close shadow
            apply(1, if0[0], 2'b00, 0, 0, 0, 0, 0, 0);
            apply(1, vf0[0], 2'b10, 3, 0, 1, 0, 0, 0);
            apply(0, 0, 2'b00, 0, 0, 0, 0, 0, 1);
            a = model(s[0], m[1:0], c, i, vm[0], pv[0], vp[0]);
            e_if  = (a == 1) ? s[0] : if0[0];
            e_vf  = (a == 2) ? s[0] : vf0[0];
            e_evt = (a == 1) && s[0] && !if0[0];
            e_sh  = e_evt;
            e_flt = (a == 3);
            if (m == 1)      tag = s ? "R4" : "R3";
            else if (m == 2) tag = s ? "R6" : "R5";
            else             tag = "R2";
            apply(1, s[0], m[1:0], c[1:0], i[1:0], vm[0], pv[0], vp[0], 0);
            check({tag, " if"}, intr_flag, e_if);
            check({tag, " vif"}, virt_flag, e_vf);
            check({"R7 fault ", tag}, gp_fault, e_flt);
            if (e_flt) check("R7 errcode", gp_err_code, 0);
            check({"R8 evt ", tag}, async_evt, e_evt);
            check({"R8 shadow ", tag}, intr_shadow, e_sh);
            // R10 / R7: strobes last one cycle, idle changes nothing
            @(negedge clk);
            check("R10 idle strobes", {gp_fault, async_evt}, 0);
            check("R10 idle flags", {intr_flag, virt_flag}, {e_if, e_vf});
            check("R9 shadow held", intr_shadow, e_sh);
        end

        // R9: raise and retire in the same cycle, raise wins
        apply(1, 0, 2'b00, 0, 0, 0, 0, 0, 1);
        apply(1, 1, 2'b00, 0, 0, 0, 0, 0, 1);
        check("R9 same-cycle raise", intr_shadow, 1);
        repeat (3) @(negedge clk);
        check("R9 held without retire", intr_shadow, 1);
        apply(0, 0, 2'b00, 0, 0, 0, 0, 0, 1);
        check("R9 retire closes", intr_shadow, 0);
        // R9: clear op with retire: shadow closes while IF falls
        apply(1, 0, 2'b00, 0, 0, 0, 0, 0, 0);
        apply(1, 1, 2'b00, 0, 0, 0, 0, 0, 0);
        apply(1, 0, 2'b00, 0, 0, 0, 0, 0, 1);
        check("R9 clear+retire shadow", intr_shadow, 0);
        check("R9 clear+retire if", intr_flag, 0);
        // R8: set with IF already 1 leaves shadow closed
        apply(1, 1, 2'b00, 0, 0, 0, 0, 0, 0);
        apply(0, 0, 2'b00, 0, 0, 0, 0, 0, 1);
        apply(1, 1, 2'b01, 0, 0, 0, 0, 0, 0);
        check("R8 no reraise", {intr_shadow, async_evt}, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule